// File: doc/BRIEF.md
# Smart-Battery Register Slave on SMBus

This block is the host-facing register file of a battery-pack controller. It watches a two-wire SMBus (clock and data, both sampled into the local clock domain). It answers to one fixed 7-bit slave address and serves word-read and word-write transactions. Each transaction picks a 16-bit register with a one-byte command code. Software-visible settings such as capacity, cycle count and serial number can be written by the host. Measurements such as pack voltage, current, temperature and the two cell voltages are written by the rest of the chip through a parallel update port, and the host can only read them.

The block also recovers from a stuck or abandoned bus. If the clock stays low too long during a transaction, the slave drops the transaction and lets go of the data line. If both lines sit high too long in the middle of a transaction, the slave discards the partial transaction. In both cases the slave ignores everything up to the next START. Both limits are parameters counted in local clock cycles.

Top module: `smb_battery_slave`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits equal `SLAVE_ADDR`. It does not acknowledge any other address, and it never pulls the data line low while no transaction is active.
- R2: A word read (address with bit0=0, command, repeated START, address with bit0=1) returns the low byte first and then the high byte, each MSB first. Data changes only while the clock is low.
- R3: After reset these registers hold the listed values, and all other registers hold 0: 0x10=7200, 0x18=7200, 0x14=2500, 0x15=12600, 0x19=10800, 0x1a=0x0031, 0x1c=0x0001.
- R4: Commands 0x00, 0x03, 0x0f, 0x17, 0x18, 0x19, 0x1a and 0x1c are host-writable. A word write to one of them is acknowledged on every byte and can be read back. A register changes only when the high data byte has been received.
- R5: For a read-only command (0x08–0x0d, 0x10, 0x14, 0x15, 0x16, 0x3e, 0x3f) or an unknown command, the command byte is still acknowledged, but the first data byte of a write is not acknowledged and no register changes.
- R6: A read of an unknown command code returns 0xFFFF.
- R7: The update port writes `updData` into the read-only register selected by `updCmd` when `updValid` is high. Measured values appear at 0x09 (voltage, mV), 0x0a (signed current, mA), 0x0b (signed average current), 0x08 (temperature, 0.1 K), 0x3f (cell 1) and 0x3e (cell 2). An update aimed at a writable or unknown command has no effect.
- R8: If the clock stays low for `TIMEOUT_CYC` cycles during a transaction, the slave releases the data line and ignores the bus until the next START.
- R9: If clock and data both stay high for `IDLE_CYC` cycles during a transaction, the transaction is abandoned. Later bytes are neither acknowledged nor written until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| sdaLow | output | 1 | 1 pulls the open-drain data line low |
| updValid | input | 1 | Measurement update strobe |
| updCmd | input | 8 | Command code of the register to update |
| updData | input | 16 | Measurement value |

## Verification
The hardest cases to reach are the two recovery paths. In both, the slave must give up in a state where a careless design would keep going. For the clock-low timeout, the bench stops the clock just after the eighth address bit, while the slave is driving its acknowledge. It checks that the data line is still held shortly after, and released once the limit has passed. For the idle abort, the bench raises data and then clock mid-write without forming a STOP, waits past the limit, and then clocks in a full high byte. It checks that this byte is neither acknowledged nor written.

// File: rtl/smb_batt_pkg.sv
package smb_batt_pkg;
  localparam int NREG = 20;
  localparam int NRW = 8;
  localparam int IW = 5;
  localparam logic [IW-1:0] NO_IDX = '1;

  typedef struct packed {
    logic        commit;
    logic [7:0]  cmd;
    logic [15:0] data;
  } hostWr_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_CMD, ST_WLO, ST_WHI, ST_ACK, ST_TX, ST_MACK, ST_WAIT
  } busState_t;

  // writable registers occupy the low indices
  function automatic logic [7:0] cmdOf(int i);
    case (i)
      0: cmdOf = 8'h00;  1: cmdOf = 8'h03;  2: cmdOf = 8'h0f;  3: cmdOf = 8'h17;
      4: cmdOf = 8'h18;  5: cmdOf = 8'h19;  6: cmdOf = 8'h1a;  7: cmdOf = 8'h1c;
      8: cmdOf = 8'h08;  9: cmdOf = 8'h09; 10: cmdOf = 8'h0a; 11: cmdOf = 8'h0b;
     12: cmdOf = 8'h0c; 13: cmdOf = 8'h0d; 14: cmdOf = 8'h10; 15: cmdOf = 8'h14;
     16: cmdOf = 8'h15; 17: cmdOf = 8'h16; 18: cmdOf = 8'h3e; 19: cmdOf = 8'h3f;
      default: cmdOf = 8'hff;
    endcase
  endfunction

  function automatic logic [15:0] regDefault(int i);
    case (i)
      4, 14:   regDefault = 16'd7200;
      5:       regDefault = 16'd10800;
      6:       regDefault = 16'h0031;
      7:       regDefault = 16'h0001;
      15:      regDefault = 16'd2500;
      16:      regDefault = 16'd12600;
      default: regDefault = 16'h0000;
    endcase
  endfunction

  function automatic logic [IW-1:0] cmdIndex(logic [7:0] c);
    cmdIndex = NO_IDX;
    for (int i = 0; i < NREG; i++)
      if (cmdOf(i) == c) cmdIndex = IW'(i);
  endfunction
endpackage

// File: rtl/smb_batt_regbank.sv
module smb_batt_regbank
  import smb_batt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  hostWr_t     hostWr,
  input  logic        updValid,
  input  logic [7:0]  updCmd,
  input  logic [15:0] updData,
  input  logic [7:0]  lookCmd,
  output logic [15:0] rdWord,
  output logic        lookWritable
);
  logic [NREG-1:0][15:0] regs;
  logic [IW-1:0] lookIdx, wrIdx, updIdx;

  assign lookIdx = cmdIndex(lookCmd);
  assign wrIdx   = cmdIndex(hostWr.cmd);
  assign updIdx  = cmdIndex(updCmd);
  assign lookWritable = (lookIdx < IW'(NRW));

  always_comb begin
    rdWord = 16'hFFFF;
    for (int i = 0; i < NREG; i++)
      if (lookIdx == IW'(i)) rdWord = regs[i];
  end

  for (genvar g = 0; g < NREG; g++) begin : gReg
    localparam logic [15:0] DEF = regDefault(g);
    if (g < NRW) begin : gRw
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) regs[g] <= DEF;
        else if (hostWr.commit && wrIdx == IW'(g)) regs[g] <= hostWr.data;
    end else begin : gRo
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) regs[g] <= DEF;
        else if (updValid && updIdx == IW'(g)) regs[g] <= updData;
    end
  end

  // R5: the controller commits only to a command this bank calls writable
  assert_commit_writable_R5: assert property (@(posedge clk) disable iff (!rstN)
    hostWr.commit |-> (cmdIndex(hostWr.cmd) < IW'(NRW)));
  // R4: no register moves without a commit or an update
  assert_regs_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!hostWr.commit && !updValid) |=> $stable(regs));
endmodule

// File: rtl/smb_batt_ctrl.sv
module smb_batt_ctrl
  import smb_batt_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h0B,
  parameter int TIMEOUT_CYC = 300000,
  parameter int IDLE_CYC = 500
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  output logic        sdaLow,
  input  logic [15:0] rdWord,
  input  logic        lookWritable,
  output logic [7:0]  lookCmd,
  output hostWr_t     hostWr
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam int HW = $clog2(IDLE_CYC + 1);

  logic sclMeta, sclS, sclPrev, sdaMeta, sdaS, sdaPrev;
  busState_t state, afterAck;
  logic [7:0] shiftReg, txByte, loByte, cmdReg;
  logic [15:0] rdHold;
  logic [3:0] bitCnt;
  logic ackDrive, cmdValid, txHi, mAck;
  logic [TW-1:0] lowCnt;
  logic [HW-1:0] hiCnt;
  logic sclRise, sclFall, startEv, stopEv, abort;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) {sclMeta, sclS, sclPrev, sdaMeta, sdaS, sdaPrev} <= '1;
    else begin
      sclMeta <= sclIn; sclS <= sclMeta; sclPrev <= sclS;
      sdaMeta <= sdaIn; sdaS <= sdaMeta; sdaPrev <= sdaS;
    end

  assign sclRise = sclS && !sclPrev;
  assign sclFall = !sclS && sclPrev;
  assign startEv = sclS && sclPrev && sdaPrev && !sdaS;
  assign stopEv  = sclS && sclPrev && !sdaPrev && sdaS;
  assign abort   = (state != ST_IDLE) &&
                   (lowCnt >= TW'(TIMEOUT_CYC) || hiCnt >= HW'(IDLE_CYC));

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      lowCnt <= '0; hiCnt <= '0;
    end else begin
      if (state == ST_IDLE || sclS) lowCnt <= '0;
      else if (lowCnt < TW'(TIMEOUT_CYC)) lowCnt <= lowCnt + 1'b1;
      if (state == ST_IDLE || !(sclS && sdaS)) hiCnt <= '0;
      else if (hiCnt < HW'(IDLE_CYC)) hiCnt <= hiCnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      state <= ST_IDLE; afterAck <= ST_WAIT; shiftReg <= '0; txByte <= '0;
      loByte <= '0; cmdReg <= '0; rdHold <= '0; bitCnt <= '0;
      ackDrive <= 1'b0; cmdValid <= 1'b0; txHi <= 1'b0; mAck <= 1'b0;
      hostWr <= '0;
    end else begin
      hostWr.commit <= 1'b0;
      if (abort || stopEv) begin
        state <= ST_IDLE; ackDrive <= 1'b0; cmdValid <= 1'b0;
      end else if (startEv) begin
        state <= ST_ADDR; bitCnt <= '0; ackDrive <= 1'b0;
      end else if (sclRise) begin
        case (state)
          ST_ADDR, ST_CMD, ST_WLO, ST_WHI: begin
            shiftReg <= {shiftReg[6:0], sdaS};
            bitCnt <= bitCnt + 1'b1;
          end
          ST_TX:   bitCnt <= bitCnt + 1'b1;
          ST_MACK: mAck <= !sdaS;
          default: ;
        endcase
      end else if (sclFall) begin
        case (state)
          ST_ADDR: if (bitCnt == 4'd8) begin
            state <= ST_ACK; bitCnt <= '0;
            if (shiftReg[7:1] == SLAVE_ADDR && !shiftReg[0]) begin
              ackDrive <= 1'b1; afterAck <= ST_CMD; cmdValid <= 1'b0;
            end else if (shiftReg[7:1] == SLAVE_ADDR && cmdValid) begin
              ackDrive <= 1'b1; afterAck <= ST_TX;
              rdHold <= rdWord; txByte <= rdWord[7:0]; txHi <= 1'b0;
            end else begin
              ackDrive <= 1'b0; afterAck <= ST_WAIT;
            end
          end
          ST_CMD: if (bitCnt == 4'd8) begin
            state <= ST_ACK; bitCnt <= '0; cmdReg <= shiftReg; cmdValid <= 1'b1;
            ackDrive <= 1'b1; afterAck <= ST_WLO;
          end
          ST_WLO: if (bitCnt == 4'd8) begin
            state <= ST_ACK; bitCnt <= '0; loByte <= shiftReg;
            ackDrive <= lookWritable;
            afterAck <= lookWritable ? ST_WHI : ST_WAIT;
          end
          ST_WHI: if (bitCnt == 4'd8) begin
            state <= ST_ACK; bitCnt <= '0; ackDrive <= 1'b1; afterAck <= ST_WAIT;
            hostWr <= '{commit: 1'b1, cmd: cmdReg, data: {shiftReg, loByte}};
          end
          ST_ACK: begin
            state <= afterAck; ackDrive <= 1'b0; bitCnt <= '0;
          end
          ST_TX: if (bitCnt == 4'd8) begin
            state <= ST_MACK; bitCnt <= '0;
          end else txByte <= {txByte[6:0], 1'b1};
          ST_MACK: if (mAck && !txHi) begin
            state <= ST_TX; txByte <= rdHold[15:8]; txHi <= 1'b1;
          end else state <= ST_WAIT;
          default: ;
        endcase
      end
    end

  assign lookCmd = cmdReg;
  assign sdaLow = (state == ST_ACK && ackDrive) || (state == ST_TX && !txByte[7]);

  // R1: the data line is left alone outside a transaction
  assert_idle_release_R1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !sdaLow);
  // R2: the slave moves the data line only while the clock is low
  assert_sda_moves_clk_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    (sdaLow != $past(sdaLow)) |-> !sclS);
  // R8: a clock held low past the limit ends the transaction
  assert_timeout_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    (lowCnt >= TW'(TIMEOUT_CYC)) |=> (state == ST_IDLE && !sdaLow));
  // R9: both lines high past the limit ends the transaction
  assert_idle_abort_R9: assert property (@(posedge clk) disable iff (!rstN)
    (hiCnt >= HW'(IDLE_CYC)) |=> (state == ST_IDLE));
endmodule

// File: rtl/smb_battery_slave.sv
module smb_battery_slave
  import smb_batt_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h0B,
  parameter int TIMEOUT_CYC = 300000,
  parameter int IDLE_CYC = 500
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  output logic        sdaLow,
  input  logic        updValid,
  input  logic [7:0]  updCmd,
  input  logic [15:0] updData
);
  hostWr_t hostWr;
  logic [7:0] lookCmd;
  logic [15:0] rdWord;
  logic lookWritable;

  smb_batt_ctrl #(.SLAVE_ADDR(SLAVE_ADDR), .TIMEOUT_CYC(TIMEOUT_CYC), .IDLE_CYC(IDLE_CYC))
    ctrl_i (.clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .sdaLow(sdaLow),
            .rdWord(rdWord), .lookWritable(lookWritable), .lookCmd(lookCmd), .hostWr(hostWr));

  smb_batt_regbank bank_i (.clk(clk), .rstN(rstN), .hostWr(hostWr), .updValid(updValid),
    .updCmd(updCmd), .updData(updData), .lookCmd(lookCmd), .rdWord(rdWord),
    .lookWritable(lookWritable));
endmodule

// File: tb/smb_battery_slave_tb.sv
`timescale 1ns/1ps
module smb_battery_slave_tb_top;
  localparam logic [6:0] ADDR = 7'h0B;
  localparam int TMO = 2000;
  localparam int IDL = 300;
  localparam int H = 20;

  logic clk = 0, rstN = 0, sclM = 1, sdaM = 1, updValid = 0;
  logic [7:0] updCmd = 0;
  logic [15:0] updData = 0;
  logic sdaLow, sdaLine;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  assign sdaLine = sdaM & ~sdaLow;

  smb_battery_slave #(.SLAVE_ADDR(ADDR), .TIMEOUT_CYC(TMO), .IDLE_CYC(IDL)) dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .sdaLow(sdaLow),
    .updValid(updValid), .updCmd(updCmd), .updData(updData));

  task automatic w(int n); repeat (n) @(negedge clk); endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busStart(); sdaM = 1; w(H/2); sclM = 1; w(H); sdaM = 0; w(H); sclM = 0; w(H/2); endtask
  task automatic busStop(); sdaM = 0; w(H/2); sclM = 1; w(H); sdaM = 1; w(H); endtask
  task automatic sendBit(logic b); sdaM = b; w(H/2); sclM = 1; w(H); sclM = 0; w(H/2); endtask
  task automatic recvBit(output logic b);
    sdaM = 1; w(H/2); sclM = 1; w(H/2); b = sdaLine; w(H/2); sclM = 0; w(H/2);
  endtask
  task automatic sendByte(logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    recvBit(b); ack = !b;
  endtask
  task automatic recvByte(output logic [7:0] v);
    for (int i = 7; i >= 0; i--) recvBit(v[i]);
  endtask

  task automatic readWord(logic [7:0] cmd, output logic [15:0] d, output logic allAck);
    logic a0, a1, a2;
    logic [7:0] lo, hi;
    busStart(); sendByte({ADDR, 1'b0}, a0); sendByte(cmd, a1);
    busStart(); sendByte({ADDR, 1'b1}, a2);
    recvByte(lo); sendBit(1'b0); recvByte(hi); sendBit(1'b1); busStop();
    d = {hi, lo}; allAck = a0 & a1 & a2;
  endtask

  task automatic writeWord(logic [7:0] cmd, logic [15:0] d, output logic [3:0] acks);
    busStart(); sendByte({ADDR, 1'b0}, acks[3]); sendByte(cmd, acks[2]);
    sendByte(d[7:0], acks[1]); sendByte(d[15:8], acks[0]); busStop();
  endtask

  task automatic upd(logic [7:0] c, logic [15:0] d);
    updCmd = c; updData = d; updValid = 1; w(1); updValid = 0; w(1);
  endtask

  task automatic expectRead(string req, logic [7:0] cmd, logic [15:0] exp);
    logic [15:0] d; logic ok;
    readWord(cmd, d, ok);
    chk(req, {15'd0, ok, d}, {15'd0, 1'b1, exp});
  endtask

  task automatic testReset();
    chk("R1 reset release", sdaLow, 0);
    expectRead("R3 0x10", 8'h10, 16'd7200);
    expectRead("R3 0x18", 8'h18, 16'd7200);
    expectRead("R3 0x14", 8'h14, 16'd2500);
    expectRead("R3 0x15", 8'h15, 16'd12600);
    expectRead("R3 0x19", 8'h19, 16'd10800);
    expectRead("R3 0x1a", 8'h1a, 16'h0031);
    expectRead("R3 0x1c", 8'h1c, 16'h0001);
    expectRead("R3 0x17", 8'h17, 16'h0000);
  endtask

  task automatic testAddress();
    logic a;
    busStart(); sendByte({7'h50, 1'b0}, a); busStop();
    chk("R1 foreign address nack", a, 0);
    chk("R1 released after nack", sdaLow, 0);
  endtask

  task automatic testMeasure();
    upd(8'h09, 16'h1CE8); upd(8'h0a, 16'hFE0C); upd(8'h08, 16'd2982);
    upd(8'h3f, 16'h0E74); upd(8'h3e, 16'h0E7E);
    expectRead("R7 voltage", 8'h09, 16'h1CE8);
    expectRead("R2 signed current low-first", 8'h0a, 16'hFE0C);
    expectRead("R7 temperature", 8'h08, 16'd2982);
    expectRead("R7 cell1", 8'h3f, 16'h0E74);
    expectRead("R7 cell2", 8'h3e, 16'h0E7E);
    upd(8'h18, 16'h5555);
    expectRead("R7 update to writable ignored", 8'h18, 16'd7200);
  endtask

  task automatic testWrite();
    logic [3:0] acks;
    writeWord(8'h17, 16'h1234, acks);
    chk("R4 all bytes acked", acks, 4'b1111);
    expectRead("R4 readback", 8'h17, 16'h1234);
    writeWord(8'h1c, 16'hA5C3, acks);
    expectRead("R4 serial readback", 8'h1c, 16'hA5C3);
  endtask

  task automatic testReject();
    logic [3:0] acks;
    writeWord(8'h09, 16'h0001, acks);
    chk("R5 read-only data nack", acks, 4'b1100);
    expectRead("R5 read-only unchanged", 8'h09, 16'h1CE8);
    writeWord(8'h05, 16'h0002, acks);
    chk("R5 unknown data nack", acks, 4'b1100);
    expectRead("R6 unknown reads ffff", 8'h05, 16'hFFFF);
    expectRead("R6 string cmd reads ffff", 8'h21, 16'hFFFF);
  endtask

  task automatic testTimeout();
    logic a;
    busStart();
    for (int i = 7; i >= 0; i--) sendBit(i == 0 ? 1'b0 : ADDR[i-1]);
    w(10);
    chk("R8 ack held before limit", sdaLow, 1);
    w(TMO + 20);
    chk("R8 released after timeout", sdaLow, 0);
    sendByte(8'h17, a);
    chk("R8 ignored until start", a, 0);
    busStop();
    expectRead("R8 register intact", 8'h17, 16'h1234);
  endtask

  task automatic testIdleAbort();
    logic a0, a1, a2, a3;
    busStart(); sendByte({ADDR, 1'b0}, a0); sendByte(8'h17, a1); sendByte(8'h99, a2);
    chk("R9 partial write acked", {a0, a1, a2}, 3'b111);
    sdaM = 1; w(H/2); sclM = 1; w(IDL + 40); sclM = 0; w(H/2);
    sendByte(8'h77, a3);
    chk("R9 high byte after abort nack", a3, 0);
    busStop();
    expectRead("R9 no write after abort", 8'h17, 16'h1234);
  endtask

  initial begin
    w(5); rstN = 1; w(5);
    testReset(); testAddress(); testMeasure(); testWrite();
    testReject(); testTimeout(); testIdleAbort();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule